// File: doc/BRIEF.md
# Measurement Limit Checker with Sticky Alert

This block watches the stream of conversion results produced by a round-robin measurement sequencer. Each result arrives with a channel number. The block compares it against the limits programmed for that channel. Two kinds of channel exist. Voltage or temperature channels carry a 10-bit code, and only its upper 8 bits are checked against an 8-bit upper and an 8-bit lower limit. Fan channels carry a 16-bit tachometer period and are checked against a single 16-bit upper limit, so a slow or stalled fan trips it.

A failed comparison latches a sticky status bit for the channel. Software reads the status through a two-register read port. The read clears only those bits whose channel has since reported an in-limit result. A per-channel mask keeps a channel off the active-low alert line but does not stop its status bit. Fan faults are also folded into a summary bit in the first status register.

Channels 0 to N_VT-1 are voltage or temperature channels. Channels N_VT to N_VT+N_FAN-1 are fan channels. The defaults are 5 voltage or temperature channels and 2 fan channels.

Top module: `lc_limit_alert`

## Requirements
- R1: After reset all status bits are 0 and alert_n is 1. Every mask bit is 0. Voltage and temperature upper limits are 255 and lower limits are 0. Fan limits are 65535.
- R2: A voltage or temperature channel flags when res_value[9:2] is strictly greater than its upper limit. A code equal to the limit does not flag.
- R3: A voltage or temperature channel flags when res_value[9:2] is less than or equal to its lower limit. The bits res_value[1:0] play no part in the check.
- R4: A fan channel flags when the 16-bit res_value is strictly greater than its upper limit. The lower-limit value written for a fan channel has no effect.
- R5: A status bit, once set, stays set through later in-limit results until a read clears it.
- R6: A read with rd_en clears the status bits of the selected register, but only for channels whose latest comparison was in limits. The clear is visible from the next cycle.
- R7: If a channel's result arrives in the same cycle as a read of its register, the read does not clear that channel in that cycle.
- R8: A masked channel still sets its status bit but does not drive alert_n low.
- R9: alert_n is 0 exactly while some status bit is set on a channel that is not masked.
- R10: With rd_sel=0, rd_data[7] is 1 whenever any fan status bit is set.
- R11: With rd_sel=0, rd_data[c] holds the status of voltage or temperature channel c. With rd_sel=1, rd_data[f] holds the status of fan channel N_VT+f. A read clears only bits of the selected register.
- R12: A result whose channel number is N_VT+N_FAN or above changes no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A measurement result is present this cycle |
| res_chan | input | CH_W | Channel number of the result |
| res_value | input | 16 | Result: 10-bit code in [9:0], or 16-bit fan period |
| lim_we | input | 1 | Write the limits of lim_chan |
| lim_chan | input | CH_W | Channel whose limits are written |
| lim_hi | input | 16 | Upper limit ([7:0] for voltage or temperature channels) |
| lim_lo | input | 8 | Lower limit (voltage or temperature channels only) |
| mask_we | input | 1 | Load the mask vector |
| mask_val | input | N_VT+N_FAN | New mask vector, 1 = channel kept off the alert |
| rd_en | input | 1 | Status read strobe (clears qualifying bits) |
| rd_sel | input | 1 | 0 = voltage or temperature register, 1 = fan register |
| rd_data | output | 8 | Selected status register, valid in the read cycle |
| alert_n | output | 1 | Active-low alert |

## Verification
A result presented before a clock edge shows in the status, rd_data and alert_n after that edge. The bench therefore compares both outputs at the falling edge of the next cycle. rd_data is combinational on rd_sel and is checked in the same cycle the read is issued. The clear from that read is checked one cycle later. The bench model updates once per rising edge from the inputs held across it, using the limits as they were before any limit write in that same cycle. Every falling edge compares rd_data and alert_n with the model.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int CODE_W = 10;
    localparam int LIM_W  = 8;
    localparam int TACH_W = 16;
    localparam int REG_W  = 8;
    typedef logic [LIM_W-1:0]  lim_t;
    typedef logic [TACH_W-1:0] tach_t;
endpackage

// File: rtl/lc_limit_bank.sv
module lc_limit_bank
    import lc_pkg::*;
#(
    parameter int N_VT  = 5,
    parameter int N_FAN = 2,
    parameter int CH_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lim_we,
    input  logic [CH_W-1:0]               lim_chan,
    input  tach_t                         lim_hi,
    input  lim_t                          lim_lo,
    input  logic                          mask_we,
    input  logic [N_VT+N_FAN-1:0]         mask_val,
    output logic [N_VT-1:0][LIM_W-1:0]    vt_hi,
    output logic [N_VT-1:0][LIM_W-1:0]    vt_lo,
    output logic [N_FAN-1:0][TACH_W-1:0]  fan_hi,
    output logic [N_VT+N_FAN-1:0]         mask
);
    localparam int N_CH = N_VT + N_FAN;

    typedef struct packed {
        logic [N_VT-1:0][LIM_W-1:0]   hi;
        logic [N_VT-1:0][LIM_W-1:0]   lo;
        logic [N_FAN-1:0][TACH_W-1:0] fhi;
        logic [N_CH-1:0]              msk;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        for (int c = 0; c < N_VT; c++) begin
            if (lim_we && lim_chan == CH_W'(c)) begin
                b_d.hi[c] = lim_hi[LIM_W-1:0];
                b_d.lo[c] = lim_lo;
            end
        end
        for (int f = 0; f < N_FAN; f++) begin
            if (lim_we && lim_chan == CH_W'(N_VT + f)) begin
                b_d.fhi[f] = lim_hi;
            end
        end
        if (mask_we) begin
            b_d.msk = mask_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.hi  <= '1;
            b_q.lo  <= '0;
            b_q.fhi <= '1;
            b_q.msk <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign vt_hi  = b_q.hi;
    assign vt_lo  = b_q.lo;
    assign fan_hi = b_q.fhi;
    assign mask   = b_q.msk;
endmodule

// File: rtl/lc_vt_cmp.sv
module lc_vt_cmp
    import lc_pkg::*;
(
    input  lim_t code,
    input  lim_t hi,
    input  lim_t lo,
    output logic fail
);
    logic over_d, under_d;
    always_comb begin
        over_d  = code > hi;
        under_d = code <= lo;
        fail    = over_d || under_d;
    end
endmodule

// File: rtl/lc_fan_cmp.sv
module lc_fan_cmp
    import lc_pkg::*;
(
    input  tach_t period,
    input  tach_t hi,
    output logic  fail
);
    always_comb begin
        fail = period > hi;
    end
endmodule

// File: rtl/lc_status_core.sv
module lc_status_core #(
    parameter int N_VT  = 5,
    parameter int N_FAN = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_VT+N_FAN-1:0]  hit,
    input  logic [N_VT+N_FAN-1:0]  flag,
    input  logic                   rd_en,
    input  logic                   rd_sel,
    output logic [N_VT+N_FAN-1:0]  status
);
    localparam int N_CH = N_VT + N_FAN;

    typedef struct packed {
        logic [N_CH-1:0] st;
        logic [N_CH-1:0] ok;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int c = 0; c < N_CH; c++) begin
            if (hit[c]) begin
                s_d.ok[c] = !flag[c];
                if (flag[c]) begin
                    s_d.st[c] = 1'b1;
                end
            end else if (rd_en && ((c >= N_VT) == rd_sel) && s_q.ok[c]) begin
                s_d.st[c] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st <= '0;
            s_q.ok <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign status = s_q.st;

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ((status & $past(status)) == $past(status)));

    // R6
    clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~status & $past(status)) != '0) |-> $past(rd_en));
endmodule

// File: rtl/lc_limit_alert.sv
module lc_limit_alert
    import lc_pkg::*;
#(
    parameter int N_VT  = 5,
    parameter int N_FAN = 2,
    parameter int N_CH  = N_VT + N_FAN,
    parameter int CH_W  = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [CH_W-1:0]  res_chan,
    input  logic [15:0]      res_value,
    input  logic             lim_we,
    input  logic [CH_W-1:0]  lim_chan,
    input  logic [15:0]      lim_hi,
    input  logic [7:0]       lim_lo,
    input  logic             mask_we,
    input  logic [N_CH-1:0]  mask_val,
    input  logic             rd_en,
    input  logic             rd_sel,
    output logic [7:0]       rd_data,
    output logic             alert_n
);
    localparam int SUM_BIT = REG_W - 1;

    logic [N_VT-1:0][LIM_W-1:0]   vt_hi, vt_lo;
    logic [N_FAN-1:0][TACH_W-1:0] fan_hi;
    logic [N_CH-1:0]              mask, hit, fail, flag, status;
    lim_t                         code;

    assign code = res_value[CODE_W-1:CODE_W-LIM_W];

    lc_limit_bank #(.N_VT(N_VT), .N_FAN(N_FAN), .CH_W(CH_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .lim_we(lim_we), .lim_chan(lim_chan),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .mask_we(mask_we),
        .mask_val(mask_val), .vt_hi(vt_hi), .vt_lo(vt_lo),
        .fan_hi(fan_hi), .mask(mask)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign hit[c] = res_valid && (res_chan == CH_W'(c));
        if (c < N_VT) begin : g_vt
            lc_vt_cmp cmp_i (.code(code), .hi(vt_hi[c]), .lo(vt_lo[c]),
                             .fail(fail[c]));
        end else begin : g_fan
            lc_fan_cmp cmp_i (.period(res_value), .hi(fan_hi[c-N_VT]),
                              .fail(fail[c]));
        end
    end

    assign flag = hit & fail;

    lc_status_core #(.N_VT(N_VT), .N_FAN(N_FAN)) stat_i (
        .clk(clk), .rst_n(rst_n), .hit(hit), .flag(flag),
        .rd_en(rd_en), .rd_sel(rd_sel), .status(status)
    );

    always_comb begin
        rd_data = '0;
        if (!rd_sel) begin
            for (int c = 0; c < N_VT; c++) rd_data[c] = status[c];
            rd_data[SUM_BIT] = |status[N_CH-1:N_VT];
        end else begin
            for (int f = 0; f < N_FAN; f++) rd_data[f] = status[N_VT+f];
        end
        alert_n = ~|(status & ~mask);
    end

    // R2
    set_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag) |=> ((status & $past(flag)) == $past(flag)));

    // R9
    alert_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_n) |-> ($past(res_valid) || $past(mask_we)));
endmodule

// File: tb/lc_limit_alert_tb.sv
module lc_limit_alert_tb_top;
    localparam int NV = 5;
    localparam int NF = 2;
    localparam int NC = NV + NF;

    logic clk = 0, rst_n = 0;
    logic res_valid = 0, lim_we = 0, mask_we = 0, rd_en = 0, rd_sel = 0;
    logic [2:0] res_chan = 0, lim_chan = 0;
    logic [15:0] res_value = 0, lim_hi = 0;
    logic [7:0] lim_lo = 0;
    logic [NC-1:0] mask_val = 0;
    logic [7:0] rd_data;
    logic alert_n;

    int total = 0, bad = 0;
    bit done = 0;
    string cur_req = "R1";

    int vhi[NV], vlo[NV], fhi[NF];
    bit [NC-1:0] st, ok, msk;

    always #4 clk = ~clk;

    lc_limit_alert dut_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_value(res_value), .lim_we(lim_we), .lim_chan(lim_chan),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .mask_we(mask_we),
        .mask_val(mask_val), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .alert_n(alert_n)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit mfail(int c, int v);
        int code;
        if (c < NV) begin
            code = (v >> 2) & 255;
            return (code > vhi[c]) || (code <= vlo[c]);
        end
        return v > fhi[c-NV];
    endfunction

    function automatic int exp_rd();
        int r = 0;
        if (!rd_sel) begin
            for (int c = 0; c < NV; c++) if (st[c]) r |= (1 << c);
            for (int f = 0; f < NF; f++) if (st[NV+f]) r |= 8'h80;
        end else begin
            for (int f = 0; f < NF; f++) if (st[NV+f]) r |= (1 << f);
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NV; c++) begin vhi[c] = 255; vlo[c] = 0; end
        for (int f = 0; f < NF; f++) fhi[f] = 65535;
        st = '0; ok = '1; msk = '0;
    endtask

    task automatic model_step();
        bit [NC-1:0] nst = st, nok = ok;
        for (int c = 0; c < NC; c++) begin
            if (res_valid && int'(res_chan) == c) begin
                bit f = mfail(c, int'(res_value));
                nok[c] = !f;
                if (f) nst[c] = 1;
            end else if (rd_en && ((c >= NV) == rd_sel) && ok[c]) begin
                nst[c] = 0;
            end
        end
        if (lim_we) begin
            if (int'(lim_chan) < NV) begin
                vhi[lim_chan] = int'(lim_hi) & 255;
                vlo[lim_chan] = int'(lim_lo);
            end else if (int'(lim_chan) < NC) begin
                fhi[int'(lim_chan)-NV] = int'(lim_hi);
            end
        end
        if (mask_we) msk = mask_val;
        st = nst; ok = nok;
    endtask

    task automatic tick();
        @(negedge clk);
        check({cur_req, " rd_data"}, int'(rd_data), exp_rd());
        check({cur_req, " alert_n"}, int'(alert_n), int'(~|(st & ~msk)));
        @(posedge clk);
        model_step();
        #1;
        res_valid = 0; lim_we = 0; mask_we = 0; rd_en = 0;
    endtask

    task automatic res(int ch, int v);
        res_valid = 1; res_chan = 3'(ch); res_value = 16'(v); tick();
    endtask

    task automatic rd(int sel);
        rd_en = 1; rd_sel = sel[0]; tick();
    endtask

    task automatic lim(int ch, int hi, int lo);
        lim_we = 1; lim_chan = 3'(ch); lim_hi = 16'(hi); lim_lo = 8'(lo); tick();
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state and default limits
        cur_req = "R1";
        @(negedge clk);
        check("R1 status1", int'(rd_data), 0);
        check("R1 alert_n", int'(alert_n), 1);
        rd_sel = 1; #1 check("R1 status2", int'(rd_data), 0);
        rd_sel = 0;
        @(posedge clk); #1;
        res(0, 1023); res(3, 8); res(5, 65535); res(6, 65535);
        tick();
        check("R1 defaults give no flag", int'(rd_data), 0);

        lim(0, 100, 20); lim(1, 200, 50); lim(5, 1000, 200);
        // R2: strict greater-than on the upper 8 bits
        cur_req = "R2";
        res(0, (100 << 2) | 3); tick();
        check("R2 equal code no flag", int'(rd_data[0]), 0);
        res(0, 101 << 2); tick();
        check("R2 over flags", int'(rd_data[0]), 1);
        // R9: alert follows an unmasked status bit
        cur_req = "R9";
        check("R9 alert low", int'(alert_n), 0);
        // R3: less-or-equal on the lower limit
        cur_req = "R3";
        res(1, 51 << 2); tick();
        check("R3 above low no flag", int'(rd_data[1]), 0);
        res(1, (50 << 2) | 3); tick();
        check("R3 equal low flags", int'(rd_data[1]), 1);
        // R4: fan upper limit only, lower limit ignored
        cur_req = "R4";
        res(5, 1000); res(5, 0); rd_sel = 1; tick();
        check("R4 fan equal and low ignored", int'(rd_data[0]), 0);
        res(5, 1001); tick();
        check("R4 fan over flags", int'(rd_data[0]), 1);
        // R10: summary bit
        cur_req = "R10";
        rd_sel = 0; tick();
        check("R10 summary", int'(rd_data[7]), 1);
        // R5: sticky
        cur_req = "R5";
        res(0, 60 << 2); tick();
        check("R5 sticky after pass", int'(rd_data[0]), 1);
        // R6: read clears only passed channels
        cur_req = "R6";
        rd(0); tick();
        check("R6 ch0 cleared", int'(rd_data[0]), 0);
        check("R6 ch1 still failing", int'(rd_data[1]), 1);
        rd(1); tick();
        check("R6 fan still failing", int'(rd_data[0]), 1);
        // R11: a read clears only its own register
        cur_req = "R11";
        res(5, 500); rd(0); tick();
        check("R11 fan kept by status1 read", int'(rd_data[7]), 1);
        rd(1); tick();
        check("R11 fan cleared by status2 read", int'(rd_data[0]), 0);
        // R7: same-cycle result beats clear
        cur_req = "R7";
        res_valid = 1; res_chan = 1; res_value = 16'(100 << 2);
        rd_en = 1; rd_sel = 0; tick();
        tick();
        check("R7 not cleared", int'(rd_data[1]), 1);
        rd(0); tick();
        check("R7 cleared later", int'(rd_data[1]), 0);
        check("R9 alert released", int'(alert_n), 1);
        // R8: mask
        cur_req = "R8";
        mask_we = 1; mask_val = 7'b0000100; tick();
        res(2, 0); tick();
        check("R8 masked status set", int'(rd_data[2]), 1);
        check("R8 masked no alert", int'(alert_n), 1);
        cur_req = "R9";
        mask_we = 1; mask_val = '0; tick();
        check("R9 unmask asserts", int'(alert_n), 0);
        res(2, 10 << 2); rd(0); tick();
        check("R9 alert rises", int'(alert_n), 1);
        // R12: out-of-range channel
        cur_req = "R12";
        res(7, 0); tick();
        check("R12 ignored s1", int'(rd_data), 0);
        rd_sel = 1; tick();
        check("R12 ignored s2", int'(rd_data), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule